// File: doc/BRIEF.md
# Cache-Program Page Sequencer

This block is the host side of a multi-page flash write. A single start pulse supplies a first row address, a page count and a completion mode. The block then emits, one bus cycle per clock, the command, address and data cycles that write that run of consecutive rows through the cache program flow. Page data is pulled from a byte stream, one byte for each data cycle. After every page, the block waits for the flash before loading the next page. It can watch the ready/busy line, or it can poll the status byte.

Errors reported by the flash are recorded in a per-page bitmap. One status read can flag the page just confirmed and also the page before it, and the block places each flag on the correct page. A request that names too many pages, or that runs past the end of an erase block, is refused with a one-cycle flag and produces no bus traffic.

Top module: `cachepg_seq`

## Requirements
- R1: A start with a page count of zero, above MAX_PAGES, or with (start_row mod PAGES_PER_BLOCK) + count above PAGES_PER_BLOCK raises `illegal` for one cycle, produces no bus cycle, and raises no `done`.
- R2: Each page begins with command byte 0x80, followed by ADDR_CYC address cycles. The first two address bytes are 0x00 (column). The remaining bytes carry the row, least significant byte first. The row is start_row + page index.
- R3: Each page carries exactly PAGE_BYTES data cycles (`bus_kind` 2). Each data cycle asserts `data_req` and drives `data_in` onto the bus, in stream order.
- R4: Every page except the last is closed with command byte 0x15.
- R5: The last page is closed with 0x10 when `use_status` was 0 at start, and with 0x15 when it was 1.
- R6: With `use_status` 0, no bus cycle is issued after a closing command until `rb_ready` is seen high. The block then issues command 0x70 and exactly one status read (`bus_kind` 3).
- R7: With `use_status` 1, each non-last page is followed by command 0x70 and then by status reads repeated on every cycle until status bit 6 (cache free) is 1. Only then does the next 0x80 go out.
- R8: With `use_status` 1, the last page is followed by status reads until status bit 5 (array idle) is 1.
- R9: At the status read that ends the wait after page k, status bit 0 sets `err_map[k]`, and status bit 1 sets `err_map[k-1]` when k > 0. The bitmap clears on an accepted start and otherwise only accumulates.
- R10: `done` pulses for one cycle after the last page's final status read. `busy` is high from the cycle after an accepted start until `done`.
- R11: A start pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse |
| use_status | input | 1 | 1: poll status, 0: watch ready/busy |
| start_row | input | 8*(ADDR_CYC-2) | Row address of the first page |
| page_count | input | clog2(MAX_PAGES+1) | Number of pages |
| data_in | input | 8 | Page data byte, consumed when data_req is high |
| rb_ready | input | 1 | Flash ready/busy line, high when ready |
| status_in | input | 8 | Flash status byte, sampled during a status read |
| bus_valid | output | 1 | A bus cycle is issued this clock |
| bus_kind | output | 2 | 0 command, 1 address, 2 data, 3 status read |
| bus_byte | output | 8 | Byte driven in the cycle |
| data_req | output | 1 | Data byte taken this clock |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished pulse |
| illegal | output | 1 | Request refused pulse |
| err_map | output | MAX_PAGES | Per-page error flags |

## Verification
The delicate coincidence is a single status read that blames two pages at once: bit 0 for the page just closed and bit 1 for the one before it. On the last page, that same read also ends the sequence. The bench flash model answers each status read from a fail mask indexed by the number of pages it has accepted. The masks are drawn at random, and some are chosen directly with adjacent failing pages that include the final pair. The collected bitmap must equal the mask restricted to the requested pages, with exactly one done pulse.

// File: rtl/cachepg_pkg.sv
package cachepg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DATA, ST_CONF, ST_WRB, ST_STC, ST_STR
  } seq_state_t;

  localparam logic [1:0] BK_CMD  = 2'd0;
  localparam logic [1:0] BK_ADDR = 2'd1;
  localparam logic [1:0] BK_DATA = 2'd2;
  localparam logic [1:0] BK_READ = 2'd3;

  localparam logic [7:0] CMD_LOAD  = 8'h80;
  localparam logic [7:0] CMD_CACHE = 8'h15;
  localparam logic [7:0] CMD_FINAL = 8'h10;
  localparam logic [7:0] CMD_STAT  = 8'h70;

  localparam int SB_CUR  = 0;
  localparam int SB_PREV = 1;
  localparam int SB_IDLE = 5;
  localparam int SB_CRDY = 6;
endpackage

// File: rtl/cachepg_limit.sv
module cachepg_limit #(
  parameter int MAX_PAGES       = 64,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int ROW_W           = 24,
  parameter int CNT_W           = 7
) (
  input  logic [ROW_W-1:0] start_row,
  input  logic [CNT_W-1:0] page_count,
  output logic             legal
);
  localparam int BLK_W = $clog2(PAGES_PER_BLOCK);
  localparam int SUM_W = ((CNT_W > BLK_W) ? CNT_W : BLK_W) + 1;

  logic [SUM_W-1:0] reach;

  always_comb begin
    reach = SUM_W'(start_row[BLK_W-1:0]) + SUM_W'(page_count);
    legal = (page_count != '0) &&
            (page_count <= CNT_W'(MAX_PAGES)) &&
            (reach <= SUM_W'(PAGES_PER_BLOCK));
  end
endmodule

// File: rtl/cachepg_addr.sv
module cachepg_addr #(
  parameter int ADDR_CYC = 5,
  parameter int CNT_W    = 7,
  parameter int CYC_W    = 12,
  localparam int ROW_BYTES = ADDR_CYC - 2,
  localparam int ROW_W     = 8 * ROW_BYTES
) (
  input  logic [ROW_W-1:0] row_base,
  input  logic [CNT_W-1:0] page_idx,
  input  logic [CYC_W-1:0] cyc,
  output logic [7:0]       abyte
);
  logic [ROW_W-1:0] row;

  always_comb begin
    row   = row_base + ROW_W'(page_idx);
    abyte = 8'h00;
    for (int i = 0; i < ROW_BYTES; i++) begin
      if (cyc == CYC_W'(i + 2)) abyte = row[8*i +: 8];
    end
  end
endmodule

// File: rtl/cachepg_err.sv
module cachepg_err #(
  parameter int MAX_PAGES = 64,
  localparam int IDX_W = $clog2(MAX_PAGES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 upd,
  input  logic [IDX_W-1:0]     idx,
  input  logic                 fail_cur,
  input  logic                 fail_prev,
  output logic [MAX_PAGES-1:0] err_map
);
  logic [MAX_PAGES-1:0] err_n;
  logic [IDX_W-1:0]     prev_idx;

  always_comb begin
    prev_idx = idx - IDX_W'(1);
    err_n    = err_map;
    if (clr) begin
      err_n = '0;
    end else if (upd) begin
      if (fail_cur) err_n[idx] = 1'b1;
      if (fail_prev && (idx != '0)) err_n[prev_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_map <= '0;
    else        err_map <= err_n;
  end
endmodule

// File: rtl/cachepg_seq.sv
module cachepg_seq
  import cachepg_pkg::*;
#(
  parameter int ADDR_CYC        = 5,
  parameter int PAGE_BYTES      = 2112,
  parameter int MAX_PAGES       = 64,
  parameter int PAGES_PER_BLOCK = 64,
  localparam int ROW_W = 8 * (ADDR_CYC - 2),
  localparam int CNT_W = $clog2(MAX_PAGES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 use_status,
  input  logic [ROW_W-1:0]     start_row,
  input  logic [CNT_W-1:0]     page_count,
  input  logic [7:0]           data_in,
  input  logic                 rb_ready,
  input  logic [7:0]           status_in,
  output logic                 bus_valid,
  output logic [1:0]           bus_kind,
  output logic [7:0]           bus_byte,
  output logic                 data_req,
  output logic                 busy,
  output logic                 done,
  output logic                 illegal,
  output logic [MAX_PAGES-1:0] err_map
);
  localparam int SPAN  = (PAGE_BYTES > ADDR_CYC) ? PAGE_BYTES : ADDR_CYC;
  localparam int CYC_W = $clog2(SPAN) + 1;
  localparam int IDX_W = $clog2(MAX_PAGES);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_s = rsync[1];

  seq_state_t       state, state_n;
  logic [CYC_W-1:0] cyc, cyc_n;
  logic [CNT_W-1:0] page_idx, page_idx_n;
  logic [CNT_W-1:0] count_r;
  logic [ROW_W-1:0] row_r;
  logic             stat_r;
  logic             done_q, done_n, ill_q, ill_n;
  logic             load, upd, legal, last, accept;
  logic [7:0]       abyte;

  cachepg_limit #(
    .MAX_PAGES(MAX_PAGES), .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
    .ROW_W(ROW_W), .CNT_W(CNT_W)
  ) u_limit (
    .start_row(start_row), .page_count(page_count), .legal(legal)
  );

  cachepg_addr #(.ADDR_CYC(ADDR_CYC), .CNT_W(CNT_W), .CYC_W(CYC_W)) u_addr (
    .row_base(row_r), .page_idx(page_idx), .cyc(cyc), .abyte(abyte)
  );

  cachepg_err #(.MAX_PAGES(MAX_PAGES)) u_err (
    .clk(clk), .rst_n(rst_s), .clr(load), .upd(upd),
    .idx(page_idx[IDX_W-1:0]),
    .fail_cur(status_in[SB_CUR]), .fail_prev(status_in[SB_PREV]),
    .err_map(err_map)
  );

  assign last   = (page_idx == count_r - CNT_W'(1));
  assign accept = !stat_r || (last ? status_in[SB_IDLE] : status_in[SB_CRDY]);

  always_comb begin
    state_n    = state;
    cyc_n      = cyc;
    page_idx_n = page_idx;
    bus_valid  = 1'b0;
    bus_kind   = BK_CMD;
    bus_byte   = 8'h00;
    data_req   = 1'b0;
    done_n     = 1'b0;
    ill_n      = 1'b0;
    load       = 1'b0;
    upd        = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (legal) begin
            load       = 1'b1;
            page_idx_n = '0;
            state_n    = ST_CMD;
          end else begin
            ill_n = 1'b1;
          end
        end
      end
      ST_CMD: begin
        bus_valid = 1'b1;
        bus_byte  = CMD_LOAD;
        cyc_n     = '0;
        state_n   = ST_ADDR;
      end
      ST_ADDR: begin
        bus_valid = 1'b1;
        bus_kind  = BK_ADDR;
        bus_byte  = abyte;
        if (cyc == CYC_W'(ADDR_CYC - 1)) begin
          cyc_n   = '0;
          state_n = ST_DATA;
        end else begin
          cyc_n = cyc + CYC_W'(1);
        end
      end
      ST_DATA: begin
        bus_valid = 1'b1;
        bus_kind  = BK_DATA;
        bus_byte  = data_in;
        data_req  = 1'b1;
        if (cyc == CYC_W'(PAGE_BYTES - 1)) state_n = ST_CONF;
        else                               cyc_n   = cyc + CYC_W'(1);
      end
      ST_CONF: begin
        bus_valid = 1'b1;
        bus_byte  = (last && !stat_r) ? CMD_FINAL : CMD_CACHE;
        state_n   = stat_r ? ST_STC : ST_WRB;
      end
      ST_WRB: begin
        if (rb_ready) state_n = ST_STC;
      end
      ST_STC: begin
        bus_valid = 1'b1;
        bus_byte  = CMD_STAT;
        state_n   = ST_STR;
      end
      ST_STR: begin
        bus_valid = 1'b1;
        bus_kind  = BK_READ;
        if (accept) begin
          upd = 1'b1;
          if (last) begin
            done_n  = 1'b1;
            state_n = ST_IDLE;
          end else begin
            page_idx_n = page_idx + CNT_W'(1);
            state_n    = ST_CMD;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state    <= ST_IDLE;
      cyc      <= '0;
      page_idx <= '0;
      done_q   <= 1'b0;
      ill_q    <= 1'b0;
    end else begin
      state    <= state_n;
      cyc      <= cyc_n;
      page_idx <= page_idx_n;
      done_q   <= done_n;
      ill_q    <= ill_n;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      count_r <= '0;
      row_r   <= '0;
      stat_r  <= 1'b0;
    end else if (load) begin
      count_r <= page_count;
      row_r   <= start_row;
      stat_r  <= use_status;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign done    = done_q;
  assign illegal = ill_q;
endmodule

// File: rtl/cachepg_seq_chk.sv
module cachepg_seq_chk #(
  parameter int MAX_PAGES = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 rb_ready,
  input logic                 bus_valid,
  input logic [1:0]           bus_kind,
  input logic [7:0]           bus_byte,
  input logic                 data_req,
  input logic                 busy,
  input logic                 done,
  input logic                 illegal,
  input logic                 stat_mode,
  input logic [MAX_PAGES-1:0] err_map
);
  assert_refused_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!bus_valid && !busy && !done));

  assert_data_on_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |-> (bus_valid && bus_kind == 2'd2));

  assert_final_code_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_kind == 2'd0 && bus_byte == 8'h10) |-> !stat_mode);

  assert_hold_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stat_mode && !rb_ready) |-> !bus_valid);

  assert_err_only_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_map) |-> ($past(start) || $past(bus_valid && bus_kind == 2'd3)));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind cachepg_seq cachepg_seq_chk #(.MAX_PAGES(MAX_PAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rb_ready(rb_ready),
  .bus_valid(bus_valid), .bus_kind(bus_kind), .bus_byte(bus_byte),
  .data_req(data_req), .busy(busy), .done(done), .illegal(illegal),
  .stat_mode(stat_r), .err_map(err_map)
);

// File: tb/cachepg_seq_bench.sv
module cachepg_seq_bench;
  localparam int AC  = 5;
  localparam int PB  = 8;
  localparam int MP  = 64;
  localparam int PPB = 64;
  localparam int RW  = 8 * (AC - 2);
  localparam int CW  = $clog2(MP + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, start, use_status;
  logic [RW-1:0] start_row;
  logic [CW-1:0] page_count;
  logic [7:0]    data_in, status_in;
  logic          rb_ready;
  logic          bus_valid, data_req, busy, done, illegal;
  logic [1:0]    bus_kind;
  logic [7:0]    bus_byte;
  logic [MP-1:0] err_map;

  cachepg_seq #(.ADDR_CYC(AC), .PAGE_BYTES(PB), .MAX_PAGES(MP), .PAGES_PER_BLOCK(PPB))
  u_cachepg_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .use_status(use_status),
    .start_row(start_row), .page_count(page_count), .data_in(data_in),
    .rb_ready(rb_ready), .status_in(status_in), .bus_valid(bus_valid),
    .bus_kind(bus_kind), .bus_byte(bus_byte), .data_req(data_req),
    .busy(busy), .done(done), .illegal(illegal), .err_map(err_map)
  );

  int checks = 0;
  int errors = 0;

  // flash model state
  logic        mdl_clr, tb_stat;
  logic [63:0] fail;
  int busy_cnt, pc, dcnt, log_n, done_cnt, ill_cnt, viol, done_busy;
  logic [1:0] lk [0:4095];
  logic [7:0] lb [0:4095];

  function automatic logic [7:0] dbyte(input int p, input int b);
    return 8'((p * 29 + b * 11 + 5) & 255);
  endfunction

  function automatic logic fail_at(input int idx);
    if (idx < 0 || idx > 63) return 1'b0;
    return fail[idx];
  endfunction

  assign rb_ready  = (busy_cnt == 0);
  assign data_in   = dbyte(dcnt / PB, dcnt % PB);
  assign status_in = {1'b0, busy_cnt < 3, busy_cnt == 0, 3'b000,
                      fail_at(pc - 2), fail_at(pc - 1)};

  always @(posedge clk) begin
    if (mdl_clr) begin
      busy_cnt <= 0; pc <= 0; dcnt <= 0; log_n <= 0;
      done_cnt <= 0; ill_cnt <= 0; viol <= 0; done_busy <= -1;
    end else begin
      if (bus_valid && log_n < 4096) begin
        lk[log_n] <= bus_kind;
        lb[log_n] <= bus_byte;
        log_n     <= log_n + 1;
      end
      if (bus_valid && !tb_stat && busy_cnt != 0) viol <= viol + 1;
      if (bus_valid && tb_stat && bus_kind == 2'd0 && bus_byte == 8'h80 && busy_cnt >= 3)
        viol <= viol + 1;
      if (bus_valid && bus_kind == 2'd0 && (bus_byte == 8'h10 || bus_byte == 8'h15)) begin
        busy_cnt <= 3 + int'($urandom % 6);
        pc       <= pc + 1;
      end else if (busy_cnt > 0) begin
        busy_cnt <= busy_cnt - 1;
      end
      if (data_req) dcnt <= dcnt + 1;
      if (done) begin done_cnt <= done_cnt + 1; done_busy <= busy_cnt; end
      if (illegal) ill_cnt <= ill_cnt + 1;
    end
  end

  task automatic check(input logic ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  int wi, wbad;
  function automatic void step(input logic [1:0] k, input logic [7:0] b);
    if (wi >= log_n || lk[wi] != k || lb[wi] != b) wbad++;
    wi++;
  endfunction

  function automatic int walk(input int cnt, input logic st, input int row);
    wi = 0; wbad = 0;
    for (int p = 0; p < cnt; p++) begin
      logic [RW-1:0] r = RW'(row + p);
      step(2'd0, 8'h80);
      step(2'd1, 8'h00);
      step(2'd1, 8'h00);
      for (int a = 0; a < AC - 2; a++) step(2'd1, r[8*a +: 8]);
      for (int b = 0; b < PB; b++) step(2'd2, dbyte(p, b));
      step(2'd0, (p == cnt - 1 && !st) ? 8'h10 : 8'h15);
      step(2'd0, 8'h70);
      if (wi >= log_n || lk[wi] != 2'd3) wbad++;
      if (!st) begin
        wi++;
      end else begin
        while (wi < log_n && lk[wi] == 2'd3) wi++;
      end
    end
    if (wi != log_n) wbad++;
    return wbad;
  endfunction

  task automatic run_seq(input logic st, input int row, input int cnt,
                         input logic [63:0] fm, input logic exp_ill, input logic poke);
    int w;
    logic [63:0] emask;
    @(negedge clk); mdl_clr = 1'b1;
    @(negedge clk); mdl_clr = 1'b0;
    tb_stat = st; fail = fm;
    use_status = st; start_row = RW'(row); page_count = CW'(cnt); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      use_status = ~st; start_row = RW'(row + 5); page_count = CW'(3); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    w = 0;
    while (done_cnt == 0 && ill_cnt == 0 && w < 30000) begin @(negedge clk); w++; end
    repeat (4) @(negedge clk);
    if (exp_ill) begin
      check(ill_cnt == 1, "R1 illegal pulse count", ill_cnt, 1);
      check(log_n == 0 && done_cnt == 0, "R1 no bus cycles and no done", log_n, 0);
    end else begin
      emask = (cnt >= 64) ? '1 : ((64'd1 << cnt) - 64'd1);
      check(ill_cnt == 0, "R1 legal request not refused", ill_cnt, 0);
      check(walk(cnt, st, row) == 0, "R2 R3 R4 R5 bus cycle stream", wbad, 0);
      check(viol == 0, st ? "R7 next page before cache free" : "R6 bus cycle while flash busy",
            viol, 0);
      check(done_busy == 0, "R8 done only after array idle", done_busy, 0);
      check(err_map == (fm & emask), "R9 error bitmap", err_map, fm & emask);
      check(done_cnt == 1 && !busy, poke ? "R11 restart ignored, one done" : "R10 single done",
            done_cnt, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R10 actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed_init;
    seed_init = $urandom(32'd4242);
    rst_n = 1'b0; mdl_clr = 1'b1; tb_stat = 1'b0; fail = '0;
    start = 1'b0; use_status = 1'b0; start_row = '0; page_count = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && !bus_valid && !illegal && err_map == '0,
          "R10 reset state idle", {busy, done, bus_valid, illegal}, 0);

    // directed corners
    run_seq(1'b0, 128, 1, 64'h1, 1'b0, 1'b0);
    run_seq(1'b1, 320, 1, 64'h0, 1'b0, 1'b0);
    run_seq(1'b1, 64 * 7, 64, 64'hC000_0000_0000_0003, 1'b0, 1'b0);
    run_seq(1'b0, 64 * 3 + 60, 4, 64'hC, 1'b0, 1'b0);
    run_seq(1'b1, 64 * 2 + 10, 5, 64'h18, 1'b0, 1'b0);
    run_seq(1'b0, 0, 0, 64'h0, 1'b1, 1'b0);
    run_seq(1'b1, 0, 65, 64'h0, 1'b1, 1'b0);
    run_seq(1'b0, 64 * 5 + 62, 3, 64'h0, 1'b1, 1'b0);
    run_seq(1'b1, 64 * 9 + 1, 6, 64'h21, 1'b0, 1'b1);
    run_seq(1'b0, 64 * 9 + 1, 6, 64'h12, 1'b0, 1'b1);

    // constrained random legal runs
    for (int n = 0; n < 10; n++) begin
      int cnt, off, blk;
      logic [63:0] fm;
      cnt = 1 + int'($urandom % 64);
      off = int'($urandom % (65 - cnt));
      blk = int'($urandom % 4096);
      fm  = {$urandom, $urandom} & {$urandom, $urandom};
      run_seq(1'($urandom % 2), blk * 64 + off, cnt, fm, 1'b0, 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule